// File: doc/BRIEF.md
# HDLC Receive Deframer with In-Band Status

This block sits behind a bit-clock recovery stage and turns a stream of recovered line bits into tagged 10-bit words for a host. A line bit counts only in a cycle where its valid strobe is high. The block finds the flag octets that bound each frame and deletes the zero bits the sender inserted for transparency. It spots aborts, runs a frame check over the destuffed bits and packs them into bytes, with the first bit received landing in bit 0. Every result goes into one small show-ahead FIFO: data bytes, a packet-end status word, or an abort marker. A host needs only that one read port to learn where each packet ends and whether it was good.

The frame check sequence is not stripped. Its two or four bytes arrive as ordinary data, and the host discards them once it sees the end word. A single input selects a 16-bit or a 32-bit frame check. Overflow of the FIFO and reads of an empty FIFO are reported on sticky flags, which only reset clears.

Top module: `hdlc_deframer`

## Requirements
- R1: The octet 01111110 (a 0, six 1s, a 0) on the line is a flag. Any flag puts the block inside a frame, and the flag that ends one frame also opens the next one.
- R2: Inside a frame, a 0 that follows exactly five consecutive 1s is removed. It adds nothing to the data and nothing to the frame check.
- R3: Inside a frame, the seventh consecutive 1 is an abort. One word with tag 10 and an all-zero low byte is pushed. Partial data is dropped, and no further word is pushed until the next flag.
- R4: Each group of eight destuffed bits is pushed as a word with tag 00 (bits 9:8), first bit in bit 0. A data bit is delivered only after seven more destuffed bits have followed it, so the seven bits that open a closing flag or an abort never count as data.
- R5: A flag that closes a frame that held at least one data bit pushes a word with tag 01. Bits 7:4 are zero. Bit 3 is 1 when the frame check matches. Bits 2:0 hold the count of leftover bits past the last whole byte, minus two, modulo 8, so a whole number of bytes gives 110. Leftover bits are dropped.
- R6: With the select input low, the check runs the bit-reversed CRC-16 (polynomial 0x8408, preset all ones) and expects remainder 0xF0B8. With it high, it runs the bit-reversed CRC-32 (0xEDB88320, preset all ones) and expects 0xDEBB20E3. The check covers every data bit, including the check bytes, which are also pushed as data.
- R7: Flags with no data bits between them push nothing.
- R8: The FIFO holds three words. The oldest word is always visible on the read port, and a read strobe with the FIFO not empty removes it. The empty and full outputs track the fill level.
- R9: A push into a full FIFO that is not being read in the same cycle sets the sticky overrun flag. The word is dropped and the held words stay unchanged.
- R10: A read strobe while the FIFO is empty sets the sticky underrun flag and changes nothing else.
- R11: After reset the FIFO is empty, not full, both sticky flags are low and the block hunts for a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered line bit |
| rx_bit_vld | input | 1 | Line bit is valid this cycle |
| crc32_sel | input | 1 | 0 selects the 16-bit check, 1 the 32-bit check |
| rd_en | input | 1 | Remove the oldest FIFO word |
| rd_word | output | 10 | Oldest FIFO word: tag in 9:8, payload in 7:0 |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds three words |
| overrun | output | 1 | Sticky: a word was dropped on a full FIFO |
| underrun | output | 1 | Sticky: a read was made on an empty FIFO |

## Verification
The assertions assume that the check-width select stays constant from the opening flag to the closing flag of a frame. They also assume that a line bit is valid for one cycle at a time. The stimulus changes the select only right after a flag and spaces valid bits three cycles apart. The frames it sends come from a software sender that inserts stuffing bits and appends a complemented check. The abort and overrun cases switch off automatic expectations and state their expected words explicitly, because they depend on the seven-bit delivery delay.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;
    localparam int WORD_W    = 10;
    localparam int BYTE_W    = 8;
    localparam int RUN_W     = 3;
    localparam int STUFF_RUN = 5;
    localparam int FLAG_RUN  = 6;
    localparam int RUN_SAT   = 7;

    localparam logic [15:0] POLY16 = 16'h8408;
    localparam logic [31:0] POLY32 = 32'hEDB88320;
    localparam logic [15:0] RES16  = 16'hF0B8;
    localparam logic [31:0] RES32  = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        TAG_DATA  = 2'b00,
        TAG_END   = 2'b01,
        TAG_ABORT = 2'b10
    } word_tag_e;
endpackage

// File: rtl/hdlc_bit_filter.sv
`timescale 1ns/1ps
module hdlc_bit_filter
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic ev_data,
    output logic ev_flag,
    output logic ev_abort
);
    typedef struct packed {
        logic [RUN_W-1:0] ones;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ev_data  = 1'b0;
        ev_flag  = 1'b0;
        ev_abort = 1'b0;
        if (bit_vld) begin
            if (bit_in) begin
                if (st_q.ones != RUN_W'(RUN_SAT))
                    st_d.ones = st_q.ones + 1'b1;
                if (st_q.ones == RUN_W'(FLAG_RUN))
                    ev_abort = 1'b1;
                else if (st_q.ones < RUN_W'(FLAG_RUN))
                    ev_data = 1'b1;
            end else begin
                st_d.ones = '0;
                if (st_q.ones == RUN_W'(FLAG_RUN))
                    ev_flag = 1'b1;
                else if (st_q.ones != RUN_W'(STUFF_RUN))
                    ev_data = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1, R2, R3: one line bit yields at most one event
    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_data, ev_flag, ev_abort}));
    // R3: an abort starts a saturated run; no second abort follows at once
    a_r3_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !ev_abort && st_q.ones == RUN_W'(RUN_SAT));
    // R1: a flag ends the run of ones
    a_r1_flag_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag |=> st_q.ones == '0);
endmodule

// File: rtl/hdlc_bit_delay.sv
`timescale 1ns/1ps
module hdlc_bit_delay #(
    parameter int DLY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic bit_in,
    output logic out_vld,
    output logic out_bit
);
    localparam int CW = $clog2(DLY + 1);

    typedef struct packed {
        logic [DLY-1:0] sr;
        logic [CW-1:0]  cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        out_vld = 1'b0;
        out_bit = st_q.sr[DLY-1];
        if (flush) begin
            st_d.cnt = '0;
        end else if (push) begin
            st_d.sr = {st_q.sr[DLY-2:0], bit_in};
            if (st_q.cnt == CW'(DLY)) out_vld = 1'b1;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a flush discards every pending bit
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.cnt == '0);
    // R4: the fill level never passes the delay length
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DLY));
endmodule

// File: rtl/hdlc_fcs_check.sv
`timescale 1ns/1ps
module hdlc_fcs_check
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic upd,
    input  logic bit_in,
    input  logic wide,
    output logic match
);
    typedef struct packed {
        logic [31:0] crc;
    } fcs_st_t;

    fcs_st_t st_d, st_q;
    logic    fb;

    always_comb begin
        st_d = st_q;
        fb   = st_q.crc[0] ^ bit_in;
        if (clear) begin
            st_d.crc = '1;
        end else if (upd) begin
            if (wide)
                st_d.crc = {1'b0, st_q.crc[31:1]} ^ (fb ? POLY32 : 32'h0);
            else
                st_d.crc = {st_q.crc[31:16],
                            ({1'b0, st_q.crc[15:1]} ^ (fb ? POLY16 : 16'h0))};
        end
        match = wide ? (st_q.crc == RES32) : (st_q.crc[15:0] == RES16);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    // R6: every frame starts from the all-ones preset
    a_r6_clear_presets: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.crc == '1);
    // R6: the remainder only moves on a delivered data bit
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !upd |=> $stable(st_q.crc));
endmodule

// File: rtl/hdlc_word_fifo.sv
`timescale 1ns/1ps
module hdlc_word_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head_word,
    output logic         empty,
    output logic         full,
    output logic         overrun,
    output logic         underrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
        logic                    ovr;
        logic                    und;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CW'(DEPTH)) || do_pop);
        if (pop && st_q.cnt == '0) st_d.und = 1'b1;
        if (push && !do_push)      st_d.ovr = 1'b1;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_word;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop)
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_word = st_q.mem[st_q.rd];
    assign empty     = (st_q.cnt == '0);
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign overrun   = st_q.ovr;
    assign underrun  = st_q.und;

    // R8: fill level stays within the depth
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    // R9: a rejected push flags overrun and leaves the FIFO full
    a_r9_overrun_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> overrun && full);
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R10: a read of an empty FIFO flags underrun and keeps it empty
    a_r10_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> underrun && empty);
    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/hdlc_deframer.sv
`timescale 1ns/1ps
module hdlc_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 3,
    parameter int DELAY_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic              rx_bit_vld,
    input  logic              crc32_sel,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              overrun,
    output logic              underrun
);
    localparam int NB_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              in_frame;
        logic              seen;
        logic [NB_W-1:0]   nbits;
        logic [BYTE_W-1:0] acc;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    logic              ev_data, ev_flag, ev_abort;
    logic              dly_vld, dly_bit, fcs_ok;
    logic              push;
    logic [WORD_W-1:0] push_word;

    hdlc_bit_filter i_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (rx_bit),
        .bit_vld  (rx_bit_vld),
        .ev_data  (ev_data),
        .ev_flag  (ev_flag),
        .ev_abort (ev_abort)
    );

    hdlc_bit_delay #(.DLY(DELAY_BITS)) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (ev_flag | ev_abort),
        .push    (ev_data & st_q.in_frame),
        .bit_in  (rx_bit),
        .out_vld (dly_vld),
        .out_bit (dly_bit)
    );

    hdlc_fcs_check i_fcs (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ev_flag | ev_abort),
        .upd    (dly_vld),
        .bit_in (dly_bit),
        .wide   (crc32_sel),
        .match  (fcs_ok)
    );

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_word = '0;
        if (ev_flag) begin
            if (st_q.in_frame && st_q.seen) begin
                push      = 1'b1;
                push_word = {TAG_END, 4'b0000, fcs_ok, st_q.nbits - NB_W'(2)};
            end
            st_d.in_frame = 1'b1;
            st_d.seen     = 1'b0;
            st_d.nbits    = '0;
        end else if (ev_abort) begin
            if (st_q.in_frame) begin
                push      = 1'b1;
                push_word = {TAG_ABORT, {BYTE_W{1'b0}}};
            end
            st_d.in_frame = 1'b0;
            st_d.seen     = 1'b0;
            st_d.nbits    = '0;
        end else if (dly_vld) begin
            st_d.seen  = 1'b1;
            st_d.acc   = {dly_bit, st_q.acc[BYTE_W-1:1]};
            st_d.nbits = st_q.nbits + 1'b1;
            if (st_q.nbits == NB_W'(BYTE_W - 1)) begin
                push      = 1'b1;
                push_word = {TAG_DATA, dly_bit, st_q.acc[BYTE_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hdlc_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (rd_en),
        .head_word (rd_word),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overrun   (overrun),
        .underrun  (underrun)
    );

    // R1: any flag leaves the block inside a frame
    a_r1_flag_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag |=> st_q.in_frame);
    // R3: an abort returns the block to hunting
    a_r3_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !st_q.in_frame);
    // R4: data bits reach the byte packer only inside a frame
    a_r4_data_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        dly_vld |-> st_q.in_frame);
    // R7: a flag after an empty frame pushes nothing
    a_r7_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flag && !st_q.seen |-> !push);
endmodule

// File: tb/test_hdlc_deframer.sv
`timescale 1ns/1ps
module test_hdlc_deframer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic       crc32_sel = 1'b0;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       rd_en;
    logic [9:0] rd_word;
    logic       fifo_empty, fifo_full, overrun, underrun;

    assign rd_en = mon_rd | man_rd;

    always #2.5 clk = ~clk;

    hdlc_deframer i_hdlc_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .rx_bit_vld (rx_bit_vld),
        .crc32_sel  (crc32_sel),
        .rd_en      (rd_en),
        .rd_word    (rd_word),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .overrun    (overrun),
        .underrun   (underrun)
    );

    int          checks = 0;
    int          errors = 0;
    bit          mon_en = 1'b0;
    bit          expect_on = 1'b1;
    bit          finished = 1'b0;
    string       cur_req = "R4";
    logic [9:0]  exp_q[$];
    string       req_q[$];
    logic [31:0] m_crc;
    int          m_bits, m_nb, tx_ones;
    logic [7:0]  m_acc;
    bit          m_wide;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_word(logic [9:0] w, string r);
        exp_q.push_back(w);
        req_q.push_back(r);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        mon_rd = 1'b0;
        if (mon_en && !fifo_empty) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected word", rd_word, 0);
            end else begin
                logic [9:0] e;
                string      r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(rd_word === e, r, "word", rd_word, e);
            end
            mon_rd = 1'b1;
        end
    end

    function automatic logic [31:0] crc_step(logic [31:0] c, bit b, bit wide);
        bit fb;
        fb = c[0] ^ b;
        if (wide) return {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
        return {c[31:16], ({1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0))};
    endfunction

    task automatic tx_raw(bit b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_flag();
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic frame_open(bit wide);
        crc32_sel = wide;
        m_wide = wide;
        m_crc = '1;
        m_bits = 0;
        m_nb = 0;
        m_acc = '0;
        tx_ones = 0;
    endtask

    task automatic tx_data(bit b);
        tx_raw(b);
        m_crc = crc_step(m_crc, b, m_wide);
        m_bits++;
        m_acc = {b, m_acc[7:1]};
        m_nb++;
        if (m_nb == 8) begin
            if (expect_on) expect_word({2'b00, m_acc}, cur_req);
            m_nb = 0;
        end
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                tx_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic tx_byte(logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_data(v[i]);
    endtask

    task automatic tx_fcs(bit corrupt);
        logic [31:0] f;
        f = ~m_crc;
        if (corrupt) f[3] = ~f[3];
        for (int i = 0; i < (m_wide ? 32 : 16); i++) tx_data(f[i]);
    endtask

    task automatic frame_close(string r);
        bit ok;
        if (m_bits > 0 && expect_on) begin
            ok = m_wide ? (m_crc == 32'hDEBB20E3) : (m_crc[15:0] == 16'hF0B8);
            expect_word({2'b01, 4'b0000, ok, 3'(m_nb - 2)}, r);
        end
        tx_flag();
        frame_open(m_wide);
    endtask

    task automatic drain_check(string r);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, r, "words still expected", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R11: reset state
        chk(fifo_empty == 1'b1, "R11", "empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R11", "full", fifo_full, 0);
        chk(overrun == 1'b0, "R11", "overrun", overrun, 0);
        chk(underrun == 1'b0, "R11", "underrun", underrun, 0);

        // R10: read while empty
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        chk(underrun == 1'b1, "R10", "underrun after empty read", underrun, 1);
        chk(fifo_empty == 1'b1, "R10", "still empty", fifo_empty, 1);
        do_reset();
        chk(underrun == 1'b0, "R11", "underrun cleared by reset", underrun, 0);

        mon_en = 1'b1;

        // R4 / R6: good 16-bit frame, whole bytes
        tx_flag();
        frame_open(1'b0);
        cur_req = "R4";
        tx_byte(8'hA5); tx_byte(8'h3C); tx_byte(8'h81);
        cur_req = "R6";
        tx_fcs(1'b0);
        frame_close("R5");

        // R1: closing flag of previous frame opens this one
        cur_req = "R1";
        tx_byte(8'h01); tx_byte(8'h02);
        tx_fcs(1'b0);
        frame_close("R1");

        // R6: 32-bit check
        frame_open(1'b1);
        cur_req = "R6";
        tx_byte(8'hDE); tx_byte(8'hAD); tx_byte(8'hBE); tx_byte(8'hEF);
        tx_fcs(1'b0);
        frame_close("R6");

        // R2: long runs of ones force stuffing
        frame_open(1'b0);
        cur_req = "R2";
        tx_byte(8'hFF); tx_byte(8'h7E); tx_byte(8'h3F); tx_byte(8'hF8);
        tx_fcs(1'b0);
        frame_close("R2");

        // R5: corrupted check bytes
        cur_req = "R5";
        tx_byte(8'h5A); tx_byte(8'h99);
        tx_fcs(1'b1);
        frame_close("R5");

        // R5: three leftover bits
        tx_byte(8'h55);
        tx_data(1'b1); tx_data(1'b0); tx_data(1'b1);
        frame_close("R5");
        drain_check("R5");

        // R7: back-to-back flags
        tx_flag(); tx_flag(); tx_flag();
        frame_open(1'b0);
        drain_check("R7");

        // R3: abort after three bytes; the last byte is still in the delay
        expect_word({2'b00, 8'h11}, "R3");
        expect_word({2'b00, 8'h22}, "R3");
        expect_word({2'b10, 8'h00}, "R3");
        expect_on = 1'b0;
        tx_byte(8'h11); tx_byte(8'h22); tx_byte(8'h12);
        for (int i = 0; i < 12; i++) tx_raw(1'b1);
        drain_check("R3");
        expect_on = 1'b1;
        tx_flag();
        frame_open(1'b0);
        cur_req = "R3";
        tx_byte(8'h77);
        tx_fcs(1'b0);
        frame_close("R3");
        drain_check("R3");

        // R9 / R8: overflow with reader stopped
        mon_en = 1'b0;
        expect_on = 1'b0;
        tx_byte(8'h10); tx_byte(8'h20); tx_byte(8'h30); tx_byte(8'h40);
        tx_fcs(1'b0);
        frame_close("R9");
        repeat (5) @(negedge clk);
        chk(fifo_full == 1'b1, "R8", "full", fifo_full, 1);
        chk(overrun == 1'b1, "R9", "overrun", overrun, 1);
        for (int i = 0; i < 3; i++) begin
            logic [9:0] e;
            e = {2'b00, 8'(8'h10 * (i + 1))};
            chk(rd_word === e, "R9", "kept word", rd_word, e);
            man_rd = 1'b1;
            @(negedge clk);
            man_rd = 1'b0;
        end
        chk(fifo_empty == 1'b1, "R8", "empty after drain", fifo_empty, 1);
        chk(underrun == 1'b0, "R10", "no underrun", underrun, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R11", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule